// File: doc/BRIEF.md
# Load-Modulation Answer Frame Transmitter

This block forms the answer that a contactless tag sends back to a reader. It runs on a clock at the carrier rate. It drives one load-modulation line with a square subcarrier at one sixteenth of that clock. Data is carried by reversing the phase of that subcarrier.

A one-cycle start pulse, given when the reader's request has ended, begins an answer. The block first keeps the line quiet for a guard interval. It then sends the subcarrier unmodulated for a synchronisation interval, so the reader can lock onto it. After that comes the start-of-frame mark, then each byte of the payload as a framed character. The block takes the payload bytes one at a time from a byte stream whose final byte carries a last flag. After the payload it appends a two-byte checksum, and it closes the answer with the end-of-frame mark.

Every elementary time unit lasts 8 subcarrier periods, which is 128 clock cycles. The intervals and mark lengths are parameters. Their defaults give a guard and a synchronisation interval of 128 subcarrier periods each, and marks of 10 low units followed by 2 high units.

Top module: `ansx_bpsk_tx`

## Requirements
- R1: After reset, mod_o, busy_o, done_o and byte_take_o are all low, and mod_o stays low while the block is idle.
- R2: In the clock cycle after start_i is sampled high in idle, busy_o rises. mod_o then stays low for 128 subcarrier periods (2048 cycles).
- R3: After the guard, mod_o carries the bare subcarrier for 128 periods. Counting cycles from the first cycle after start was sampled, mod_o is high in cycles 0 to 7 of each 16-cycle period and low in cycles 8 to 15.
- R4: Each bit after the synchronisation interval lasts 128 cycles. The subcarrier phase is inverted at a bit boundary exactly when the new bit differs from the previous one. The synchronisation interval counts as logic 1, so the first start-of-frame bit inverts the phase.
- R5: The start-of-frame mark is 10 bits at 0 followed by 2 bits at 1.
- R6: Each payload byte is sent as a 10-bit character: start bit 0, then data bits 0 to 7 (least significant first), then stop bit 1. Bytes go out in stream order. byte_take_o pulses once per byte, and byte_i and byte_last_i are sampled in that cycle. The byte taken with byte_last_i high is the final payload byte.
- R7: After the payload come two characters holding a CRC over the payload bytes: the low byte first, then the high byte. The CRC uses the reflected polynomial 0x8408, an initial value of 0xFFFF and a final bitwise complement (the nine ASCII bytes "123456789" give 0x906E).
- R8: The end-of-frame mark is 10 bits at 0 followed by 2 bits at 1. In the following cycle mod_o and busy_o are low and done_o is high for exactly one cycle.
- R9: A start_i pulse while busy_o is high has no effect on the answer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that begins an answer; only acted on while idle |
| byte_i | input | 8 | Payload byte offered to the block |
| byte_last_i | input | 1 | Marks byte_i as the final payload byte |
| byte_take_o | output | 1 | Pulses in the cycle byte_i and byte_last_i are consumed |
| mod_o | output | 1 | Load-modulation drive: phase-coded subcarrier, low when quiet |
| busy_o | output | 1 | High from the cycle after start until the answer ends |
| done_o | output | 1 | One-cycle pulse after the last bit of the end mark |

## Verification
The assertions assume that reset is held for several cycles before the first start. They also assume that start_i is a short pulse that arrives only once the previous answer has finished, apart from deliberate extra pulses sent mid-answer. The stream must present a valid byte whenever a take can occur, with the last flag set on exactly one byte per answer. The bench keeps to these assumptions. It loads each payload before the start pulse and advances the stream only just after a sampled take. It waits for done before it starts the next answer. It adds one extra start pulse in the middle of a single frame to exercise the ignore rule.

// File: rtl/ansx_pkg.sv
// Shared types and helpers for the answer frame transmitter.
// Assumes a reflected CRC-16 with polynomial 0x8408, processed one byte per call.
package ansx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GUARD,
        ST_SYNC,
        ST_SOF,
        ST_DATA,
        ST_CRCL,
        ST_CRCH,
        ST_EOF
    } tx_state_t;

    // Advances the running CRC register by one byte, LSB-first.
    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {8'h00, d};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/ansx_subcarrier.sv
// Subcarrier generator: divides the carrier clock by DIV into a square wave.
// The wave is high in the first half of each period.
// Assumes DIV is even; the counter is held at zero while run is low.
module ansx_subcarrier #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sc_wave,
    output logic sc_wrap
);
    localparam int W = (DIV > 2) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt;

    // Count clock cycles within one subcarrier period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == W'(DIV - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign sc_wave = (cnt < W'(DIV / 2));
    assign sc_wrap = run && (cnt == W'(DIV - 1));

    // R3: the period restarts after its final cycle.
    assert_period_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt == W'(DIV - 1)) |=> (cnt == '0));

endmodule

// File: rtl/ansx_crc16.sv
// Payload checksum register: reloads with all ones on init, and absorbs one byte per upd.
// Presents the complemented value for transmission.
// Assumes init and upd never occur in the same cycle.
module ansx_crc16 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        upd,
    input  logic [7:0]  data,
    output logic [15:0] crc_out
);
    import ansx_pkg::*;

    logic [15:0] crc_q;

    // Hold the running checksum of the bytes taken so far.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            crc_q <= 16'hFFFF;
        end else if (upd) begin
            crc_q <= crc_step(crc_q, data);
        end
    end

    assign crc_out = ~crc_q;

    // R7: the checksum moves only when a byte is absorbed or the register is reloaded.
    assert_crc_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !upd) |=> $stable(crc_out));

endmodule

// File: rtl/ansx_phase_enc.sv
// Phase encoder: tracks the previous bit level and inverts the subcarrier phase
// whenever a newly loaded bit differs from it.
// Assumes that clear starts each answer with the level treated as 1 and the phase at 0.
module ansx_phase_enc (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic load,
    input  logic bit_i,
    input  logic en,
    input  logic sc_wave,
    output logic phase_o,
    output logic mod_o
);
    logic cur_bit;

    // Update the phase at each bit boundary from the level change.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            phase_o <= 1'b0;
            cur_bit <= 1'b1;
        end else if (load) begin
            phase_o <= phase_o ^ (bit_i ^ cur_bit);
            cur_bit <= bit_i;
        end
    end

    assign mod_o = en & (sc_wave ^ phase_o);

endmodule

// File: rtl/ansx_bpsk_tx.sv
// Answer frame transmitter top: sequences guard, sync, start mark, payload characters,
// checksum characters and end mark, and drives a phase-coded subcarrier.
// Assumes start_i is a short pulse and that byte_i is valid whenever byte_take_o is high.
module ansx_bpsk_tx #(
    parameter int SUBC_DIV   = 16,
    parameter int ETU_SUBC   = 8,
    parameter int GUARD_SUBC = 128,
    parameter int SYNC_SUBC  = 128,
    parameter int MARK_LOW   = 10,
    parameter int MARK_HIGH  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] byte_i,
    input  logic       byte_last_i,
    output logic       byte_take_o,
    output logic       mod_o,
    output logic       busy_o,
    output logic       done_o
);
    import ansx_pkg::*;

    localparam int CHAR_W = 10;
    localparam int MARK_W = MARK_LOW + MARK_HIGH;
    localparam int SR_W   = (MARK_W > CHAR_W) ? MARK_W : CHAR_W;
    localparam int MAX_I  = (GUARD_SUBC > SYNC_SUBC) ?
                            ((GUARD_SUBC > ETU_SUBC) ? GUARD_SUBC : ETU_SUBC) :
                            ((SYNC_SUBC > ETU_SUBC) ? SYNC_SUBC : ETU_SUBC);
    localparam int CNT_W  = $clog2(MAX_I) + 1;
    localparam int LEFT_W = $clog2(SR_W + 1);
    localparam logic [SR_W-1:0] MARK_PAT = SR_W'(((1 << MARK_HIGH) - 1) << MARK_LOW);

    tx_state_t         state, state_n;
    logic [CNT_W-1:0]  per_cnt, per_n;
    logic [SR_W-1:0]   sr, sr_n;
    logic [LEFT_W-1:0] left, left_n;
    logic              last_q, last_n;
    logic              take, load, fin, run, en, start_ok;
    logic              sc_wave, sc_wrap, phase_w;
    logic [15:0]       crc_out;

    // Wrap a byte into a start/data/stop character, bit 0 sent first.
    function automatic logic [SR_W-1:0] char_of(input logic [7:0] b);
        return SR_W'({1'b1, b, 1'b0});
    endfunction

    assign run      = (state != ST_IDLE);
    assign start_ok = (state == ST_IDLE) && start_i;
    assign en       = (state != ST_IDLE) && (state != ST_GUARD);

    ansx_subcarrier #(.DIV(SUBC_DIV)) sc_i (
        .clk(clk), .rst_n(rst_n), .run(run), .sc_wave(sc_wave), .sc_wrap(sc_wrap)
    );

    ansx_crc16 crc_i (
        .clk(clk), .rst_n(rst_n), .init(start_ok), .upd(take), .data(byte_i), .crc_out(crc_out)
    );

    ansx_phase_enc enc_i (
        .clk(clk), .rst_n(rst_n), .clear(start_ok), .load(load), .bit_i(sr_n[0]),
        .en(en), .sc_wave(sc_wave), .phase_o(phase_w), .mod_o(mod_o)
    );

    // Choose the next segment, bit pattern and interval count.
    always_comb begin
        state_n = state;
        per_n   = sc_wrap ? per_cnt + 1'b1 : per_cnt;
        sr_n    = sr;
        left_n  = left;
        last_n  = last_q;
        take    = 1'b0;
        load    = 1'b0;
        fin     = 1'b0;
        case (state)
            ST_IDLE: begin
                per_n = '0;
                if (start_i) state_n = ST_GUARD;
            end
            ST_GUARD: begin
                if (sc_wrap && per_cnt == CNT_W'(GUARD_SUBC - 1)) begin
                    state_n = ST_SYNC;
                    per_n   = '0;
                end
            end
            ST_SYNC: begin
                if (sc_wrap && per_cnt == CNT_W'(SYNC_SUBC - 1)) begin
                    state_n = ST_SOF;
                    per_n   = '0;
                    sr_n    = MARK_PAT;
                    left_n  = LEFT_W'(MARK_W);
                    load    = 1'b1;
                end
            end
            default: begin
                if (sc_wrap && per_cnt == CNT_W'(ETU_SUBC - 1)) begin
                    per_n = '0;
                    load  = 1'b1;
                    if (left > LEFT_W'(1)) begin
                        sr_n   = sr >> 1;
                        left_n = left - 1'b1;
                    end else begin
                        left_n = LEFT_W'(CHAR_W);
                        case (state)
                            ST_SOF: begin
                                take    = 1'b1;
                                sr_n    = char_of(byte_i);
                                last_n  = byte_last_i;
                                state_n = ST_DATA;
                            end
                            ST_DATA: begin
                                if (last_q) begin
                                    sr_n    = char_of(crc_out[7:0]);
                                    state_n = ST_CRCL;
                                end else begin
                                    take   = 1'b1;
                                    sr_n   = char_of(byte_i);
                                    last_n = byte_last_i;
                                end
                            end
                            ST_CRCL: begin
                                sr_n    = char_of(crc_out[15:8]);
                                state_n = ST_CRCH;
                            end
                            ST_CRCH: begin
                                sr_n    = MARK_PAT;
                                left_n  = LEFT_W'(MARK_W);
                                state_n = ST_EOF;
                            end
                            default: begin
                                load    = 1'b0;
                                fin     = 1'b1;
                                state_n = ST_IDLE;
                            end
                        endcase
                    end
                end
            end
        endcase
    end

    // Register the sequencer state and the end-of-answer pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            per_cnt <= '0;
            sr      <= '0;
            left    <= '0;
            last_q  <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            state   <= state_n;
            per_cnt <= per_n;
            sr      <= sr_n;
            left    <= left_n;
            last_q  <= last_n;
            done_o  <= fin;
        end
    end

    assign busy_o      = run;
    assign byte_take_o = take;

    // R2: the line stays quiet throughout the guard interval.
    assert_guard_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GUARD) |-> !mod_o);
    // R4: a phase inversion only happens at a subcarrier period boundary.
    assert_phase_on_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && phase_w != $past(phase_w)) |-> $past(sc_wrap));
    // R6: a byte taken always starts a fresh payload character.
    assert_take_starts_char_R6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_take_o |=> (state == ST_DATA && left == LEFT_W'(CHAR_W)));
    // R8: done follows the busy period and lasts one cycle.
    assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R9: a start while busy never restarts the guard.
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (state != ST_GUARD || $past(state) == ST_GUARD));

endmodule

// File: tb/ansx_bpsk_tx_tb_top.sv
// Scoreboard bench: the driver task pushes one expected item per clock cycle of an answer.
// A monitor process pops the items and compares them with the ports at each falling edge.
module ansx_bpsk_tx_tb_top;

    localparam int SC   = 16;
    localparam int ETU  = 128;
    localparam int GRD  = 128 * SC;
    localparam int SYN  = 128 * SC;

    typedef struct {
        logic mod;
        logic busy;
        logic done;
        int   req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i;
    logic [7:0] byte_i;
    logic       byte_last_i;
    logic       byte_take_o, mod_o, busy_o, done_o;

    item_t      expq[$];
    logic [7:0] frame[$];
    int         idx, takes;
    int         total = 0;
    int         bad = 0;
    bit         finished = 1'b0;

    always #5 clk = ~clk;

    ansx_bpsk_tx dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_i(byte_i),
        .byte_last_i(byte_last_i), .byte_take_o(byte_take_o),
        .mod_o(mod_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Bench CRC computed bit by bit from the stated polynomial, init and complement.
    function automatic logic [15:0] ref_crc(input logic [7:0] b[$]);
        logic [15:0] c;
        c = 16'hFFFF;
        foreach (b[k]) begin
            for (int i = 0; i < 8; i++) begin
                logic fb;
                fb = c[0] ^ b[k][i];
                c  = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
        end
        return ~c;
    endfunction

    function automatic string req_name(input int r);
        return $sformatf("R%0d", r);
    endfunction

    // Byte stream feeder: advance just after an edge where a take was sampled.
    initial begin
        forever begin
            bit t;
            @(negedge clk);
            t = byte_take_o;
            if (t) takes++;
            @(posedge clk);
            #1;
            if (t) idx++;
            byte_i      = (idx < frame.size()) ? frame[idx] : 8'h00;
            byte_last_i = (idx == frame.size() - 1);
        end
    end

    // Monitor: compare one expected item per cycle.
    initial begin
        forever begin
            @(negedge clk);
            if (expq.size() > 0) begin
                item_t it;
                it = expq.pop_front();
                chk(mod_o == it.mod, req_name(it.req), "mod_o", mod_o, it.mod);
                if (busy_o != it.busy) chk(1'b0, req_name(it.req), "busy_o", busy_o, it.busy);
                if (done_o != it.done) chk(1'b0, req_name(it.req), "done_o", done_o, it.done);
            end
        end
    end

    // Push the 128-cycle waveform for one bit, inverting phase on a level change (R4).
    task automatic push_bit(input bit b, inout bit ph, inout bit prev, inout int j, input int req);
        if (b != prev) ph = ~ph;
        prev = b;
        for (int c = 0; c < ETU; c++) begin
            expq.push_back('{mod: (((j % SC) < SC / 2) ? 1'b1 : 1'b0) ^ ph, busy: 1'b1, done: 1'b0, req: req});
            j++;
        end
    endtask

    task automatic push_mark(inout bit ph, inout bit prev, inout int j, input int req);
        for (int k = 0; k < 10; k++) push_bit(1'b0, ph, prev, j, req);
        for (int k = 0; k < 2; k++) push_bit(1'b1, ph, prev, j, req);
    endtask

    task automatic push_char(input logic [7:0] v, inout bit ph, inout bit prev, inout int j, input int req);
        push_bit(1'b0, ph, prev, j, req);
        for (int k = 0; k < 8; k++) push_bit(v[k], ph, prev, j, req);
        push_bit(1'b1, ph, prev, j, req);
    endtask

    // Driver: load the stream, pulse start, then push the whole expected answer.
    task automatic run_frame(input logic [7:0] bytes[$], input bit poke);
        logic [15:0] crc;
        bit ph, prev;
        int j;
        frame       = bytes;
        idx         = 0;
        takes       = 0;
        byte_i      = frame[0];
        byte_last_i = (frame.size() == 1);
        crc         = ref_crc(bytes);
        @(negedge clk);
        start_i = 1'b1;
        @(posedge clk);
        #1;
        start_i = 1'b0;
        j = 0;
        // R2: guard interval quiet.
        for (int c = 0; c < GRD; c++) begin
            expq.push_back('{mod: 1'b0, busy: 1'b1, done: 1'b0, req: 2});
            j++;
        end
        // R3: bare subcarrier.
        for (int c = 0; c < SYN; c++) begin
            expq.push_back('{mod: ((j % SC) < SC / 2) ? 1'b1 : 1'b0, busy: 1'b1, done: 1'b0, req: 3});
            j++;
        end
        ph = 1'b0;
        prev = 1'b1;
        push_mark(ph, prev, j, 5);                               // R5 start mark
        foreach (bytes[k]) push_char(bytes[k], ph, prev, j, 6);  // R6 payload
        push_char(crc[7:0], ph, prev, j, 7);                     // R7 checksum low
        push_char(crc[15:8], ph, prev, j, 7);                    // R7 checksum high
        push_mark(ph, prev, j, 8);                               // R8 end mark
        expq.push_back('{mod: 1'b0, busy: 1'b0, done: 1'b1, req: 8});
        if (poke) begin
            fork
                begin
                    // R9: extra start in the middle of the payload.
                    repeat (GRD + SYN + 30 * ETU) @(negedge clk);
                    start_i = 1'b1;
                    @(negedge clk);
                    start_i = 1'b0;
                end
            join_none
        end
        wait (expq.size() == 0);
        @(negedge clk);
        // R8: done lasts one cycle, line quiet.
        chk(done_o == 1'b0 && mod_o == 1'b0, "R8", "done/mod after pulse", {done_o, mod_o}, 0);
        // R6: one take per payload byte.
        chk(takes == bytes.size(), "R6", "byte takes", takes, bytes.size());
        repeat (5) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1'b1;
            chk(1'b0, "R8", "watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] vec[$];
        rst_n       = 1'b0;
        start_i     = 1'b0;
        byte_i      = 8'h00;
        byte_last_i = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        @(negedge clk);
        chk(mod_o == 0 && busy_o == 0 && done_o == 0 && byte_take_o == 0, "R1", "idle outputs",
            {mod_o, busy_o, done_o, byte_take_o}, 0);
        repeat (20) @(negedge clk);
        chk(mod_o == 0 && busy_o == 0, "R1", "idle stays quiet", {mod_o, busy_o}, 0);
        // R7: reference checksum on the standard check string.
        vec = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        chk(ref_crc(vec) == 16'h906E, "R7", "check value", ref_crc(vec), 16'h906E);
        run_frame('{8'h00}, 1'b0);
        run_frame('{8'hA5, 8'h3C, 8'hFF, 8'h01}, 1'b1);
        run_frame(vec, 1'b0);
        run_frame('{8'hFF, 8'h80}, 1'b0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule